// File: doc/BRIEF.md
# Timer with Capture, Compare and Periodic Interrupt

This block is a timer subsystem. A free-running system-clock divider chain feeds a prescaler, and the prescaled tick advances a 16-bit up-counter. Software can read the counter but cannot write it. The block takes three things from that counter:

- three input-capture channels, each of which latches the count when its chosen edge arrives on an active-low pin;
- five output-compare channels, each of which raises a flag and acts on its pin when the count reaches its compare value;
- a periodic interrupt whose period is picked from four rates.

The divider chain also gives a watchdog clock pulse once every 2^17 system clocks. Every event has a flag and an enable, and each interrupt request line is the flag ANDed with its enable.

Software reaches the block through a plain register port. A write happens on the rising clock edge where `reg_we` is high. A read is combinational from `reg_addr`, and unmapped addresses read as zero. There is no handshake: every access completes in one cycle.

The register map has 16-bit words at these addresses:

| Address | Contents |
|---|---|
| 0 | Counter, read only |
| 1 | Control: prescale select [1:0], periodic rate select [3:2], capture edge code of channel i at [5+2i:4+2i] |
| 2 | Compare actions: channel i at [2i+1:2i] |
| 3 | Flags, write one to clear |
| 4 | Interrupt enables, same layout as the flags |
| 5, 6, 7 | Capture channels 0 to 2 |
| 8 to 12 | Compare channels 0 to 4 |

Flag and enable bits are laid out as follows:

| Bit | Event |
|---|---|
| 0 | Overflow |
| 1 | Periodic interrupt |
| 2, 3, 4 | Captures 0 to 2 |
| 5 to 9 | Compares 0 to 4 |

Top module: `tmr_capcmp`

## Requirements
- R1: The counter resets to 0 and rises by exactly one on each prescaled tick. It reads at address 0, and writes to address 0 leave it unchanged.
- R2: The system chain is a free-running count of clocks from reset. A prescaled tick occurs on each edge where the low k bits of the chain are all ones. Control bits [1:0] select k: code 0 gives k=0 (divide by 1), code 1 gives k=2 (divide by 4), code 2 gives k=3 (divide by 8) and code 3 gives k=4 (divide by 16).
- R3: Flag bit 0 sets on the tick where the counter holds all ones, which is the edge where the counter wraps to 0.
- R4: The edge code of a capture channel selects its edge. Code 1 is a high-to-low pin transition (assertion), code 2 is low-to-high (release) and code 3 is either. The capture register loads the counter value that is present just before the third rising clock edge after the pin changes, and flag bit 2+i sets on that edge.
- R5: A capture channel with edge code 0 neither loads its register nor sets its flag.
- R6: Compare flag bit 5+i sets on the tick where the counter equals the value at address 8+i.
- R7: On that same edge, compare pin i acts according to its code: 0 keeps the pin, 1 toggles it, 2 drives it low and 3 drives it high. The enable output of channel i is high whenever its code is nonzero.
- R8: Flag bit 1 sets on the tick where the low RTI_BASE+m counter bits are all ones, with m taken from control bits [3:2].
- R9: `wdog_tick` is high for exactly the clock cycles in which the WDOG_LOG2-bit system chain holds all ones.
- R10: Writing ones to address 3 clears those flags. If a flag's event occurs on the same edge as the write, the flag ends up set.
- R11: `irq` is the flag vector ANDed bitwise with the enable register at address 4.
- R12: Reset clears the flags, enables, control, actions, capture registers and compare pins, and sets every compare register to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| cap_n | input | 3 | Capture pins, active low |
| oc_pin | output | 5 | Compare output pins |
| oc_en | output | 5 | Compare output enables |
| irq | output | 10 | Interrupt requests, flag AND enable |
| wdog_tick | output | 1 | Watchdog clock pulse from the divider chain |

## Verification
The collision that matters here is a compare match and a software clear of that same compare flag landing on one clock edge. The bench provokes it by waiting with divide-by-16 until the counter equals the compare value and the chain is one clock short of a tick, then issuing the write-one-to-clear on that exact edge. The flag must read set afterwards, and a second clear on a quiet edge must then take it to zero. Random compare values, pin actions, prescale codes and capture timing are checked against counter and pin expectations that the bench works out from the requirements.

// File: rtl/tmr_capcmp_pkg.sv
package tmr_capcmp_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } cap_edge_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_LOW    = 2'd2,
    PIN_HIGH   = 2'd3
  } cmp_act_e;

  localparam int unsigned FLG_OVF  = 0;
  localparam int unsigned FLG_RTI  = 1;
  localparam int unsigned FLG_CAP0 = 2;

  localparam logic [3:0] ADR_CNT  = 4'd0;
  localparam logic [3:0] ADR_CTRL = 4'd1;
  localparam logic [3:0] ADR_ACT  = 4'd2;
  localparam logic [3:0] ADR_FLAG = 4'd3;
  localparam logic [3:0] ADR_IEN  = 4'd4;
  localparam logic [3:0] ADR_CAP0 = 4'd5;

  // low chain bits that must be all ones for a prescaled tick
  function automatic logic [3:0] presc_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'h0;
      2'd1:    return 4'h3;
      2'd2:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_capcmp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WDOG_LOG2 = 17,
  parameter int RTI_BASE  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       psel,
  input  logic [1:0]       rsel,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             ovf_ev,
  output logic             rti_ev,
  output logic             wdog_tick
);
  logic [WDOG_LOG2-1:0] chain;
  logic [3:0]           pmask;
  logic [CNT_W-1:0]     rmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      cnt   <= '0;
    end else begin
      chain <= chain + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    pmask     = presc_mask(psel);
    tick      = (chain[3:0] & pmask) == pmask;
    rmask     = ~({CNT_W{1'b1}} << (RTI_BASE + int'(rsel)));
    ovf_ev    = tick && (&cnt);
    rti_ev    = tick && ((cnt & rmask) == rmask);
    wdog_tick = &chain;
  end
endmodule

// File: rtl/tmr_icap.sv
module tmr_icap
  import tmr_capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_n,
  input  logic [1:0]       esel,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic [CNT_W-1:0] value
);
  // [0],[1] synchronizer, [2] previous synchronized level
  logic [2:0] sy;
  logic       rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy    <= '0;
      value <= '0;
    end else begin
      sy <= {sy[1:0], ~pin_n};
      if (hit) value <= cnt;
    end
  end

  always_comb begin
    rise = sy[1] & ~sy[2];
    fall = ~sy[1] & sy[2];
    case (cap_edge_e'(esel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_ocmp.sv
module tmr_ocmp
  import tmr_capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       act,
  output logic             hit,
  output logic             pin
);
  assign hit = tick && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (hit) begin
      case (cmp_act_e'(act))
        PIN_TOGGLE: pin <= ~pin;
        PIN_LOW:    pin <= 1'b0;
        PIN_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_capcmp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int N_CAP     = 3,
  parameter int N_CMP     = 5,
  parameter int WDOG_LOG2 = 17,
  parameter int RTI_BASE  = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [3:0]               reg_addr,
  input  logic [CNT_W-1:0]         reg_wdata,
  output logic [CNT_W-1:0]         reg_rdata,
  input  logic [N_CAP-1:0]         cap_n,
  output logic [N_CMP-1:0]         oc_pin,
  output logic [N_CMP-1:0]         oc_en,
  output logic [2+N_CAP+N_CMP-1:0] irq,
  output logic                     wdog_tick
);
  localparam int         NFLG     = 2 + N_CAP + N_CMP;
  localparam logic [3:0] ADR_CMP0 = ADR_CAP0 + 4'(N_CAP);

  logic [CNT_W-1:0]              cnt;
  logic                          tick, ovf_ev, rti_ev;
  logic [1:0]                    psel, rsel;
  logic [N_CAP-1:0][1:0]         esel;
  logic [N_CMP-1:0][1:0]         act;
  logic [NFLG-1:0]               flags, ien, set_v, clr_v;
  logic [N_CAP-1:0]              cap_hit;
  logic [N_CAP-1:0][CNT_W-1:0]   cap_val;
  logic [N_CMP-1:0]              cmp_hit;
  logic [N_CMP-1:0][CNT_W-1:0]   cmp_val;

  tmr_chain #(.CNT_W(CNT_W), .WDOG_LOG2(WDOG_LOG2), .RTI_BASE(RTI_BASE)) u_chain (
    .clk(clk), .rst(rst), .psel(psel), .rsel(rsel), .cnt(cnt), .tick(tick),
    .ovf_ev(ovf_ev), .rti_ev(rti_ev), .wdog_tick(wdog_tick)
  );

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    tmr_icap #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .pin_n(cap_n[i]), .esel(esel[i]), .cnt(cnt),
      .hit(cap_hit[i]), .value(cap_val[i])
    );
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    tmr_ocmp #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .cmp(cmp_val[i]), .act(act[i]),
      .hit(cmp_hit[i]), .pin(oc_pin[i])
    );
    assign oc_en[i] = (act[i] != PIN_KEEP);
  end

  assign set_v = {cmp_hit, cap_hit, rti_ev, ovf_ev};
  assign clr_v = (reg_we && reg_addr == ADR_FLAG) ? reg_wdata[NFLG-1:0] : '0;
  assign irq   = flags & ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      psel    <= '0;
      rsel    <= '0;
      esel    <= '0;
      act     <= '0;
      ien     <= '0;
      flags   <= '0;
      cmp_val <= '1;
    end else begin
      if (reg_we && reg_addr == ADR_CTRL) begin
        psel <= reg_wdata[1:0];
        rsel <= reg_wdata[3:2];
        for (int i = 0; i < N_CAP; i++) esel[i] <= reg_wdata[4+2*i +: 2];
      end
      if (reg_we && reg_addr == ADR_ACT)
        for (int i = 0; i < N_CMP; i++) act[i] <= reg_wdata[2*i +: 2];
      if (reg_we && reg_addr == ADR_IEN) ien <= reg_wdata[NFLG-1:0];
      for (int i = 0; i < N_CMP; i++)
        if (reg_we && reg_addr == ADR_CMP0 + 4'(i)) cmp_val[i] <= reg_wdata;
      // a new event outranks a same-edge clear
      flags <= (flags & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CNT:  reg_rdata = cnt;
      ADR_CTRL: begin
        reg_rdata[1:0] = psel;
        reg_rdata[3:2] = rsel;
        for (int i = 0; i < N_CAP; i++) reg_rdata[4+2*i +: 2] = esel[i];
      end
      ADR_ACT:  for (int i = 0; i < N_CMP; i++) reg_rdata[2*i +: 2] = act[i];
      ADR_FLAG: reg_rdata[NFLG-1:0] = flags;
      ADR_IEN:  reg_rdata[NFLG-1:0] = ien;
      default:  ;
    endcase
    for (int i = 0; i < N_CAP; i++)
      if (reg_addr == ADR_CAP0 + 4'(i)) reg_rdata = cap_val[i];
    for (int i = 0; i < N_CMP; i++)
      if (reg_addr == ADR_CMP0 + 4'(i)) reg_rdata = cmp_val[i];
  end
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 3,
  parameter int N_CMP = 5
) (
  input logic                           clk,
  input logic                           rst,
  input logic [CNT_W-1:0]               cnt,
  input logic [2+N_CAP+N_CMP-1:0]       flags,
  input logic [N_CMP-1:0]               oc_pin,
  input logic                           wdog_tick,
  input logic [N_CAP-1:0][CNT_W-1:0]    cap_val
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  // R3
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> (cnt == '0));

  // R7
  pin_move_chk: assert property (@(posedge clk) disable iff (rst)
    ((oc_pin ^ $past(oc_pin)) & ~flags[2+N_CAP +: N_CMP]) == '0);

  // R9
  wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_tick |=> !wdog_tick);

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    // R4
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_val[i] != $past(cap_val[i])) |-> flags[2+i]);
  end
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CNT_W(CNT_W), .N_CAP(N_CAP), .N_CMP(N_CMP)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .flags(flags), .oc_pin(oc_pin),
  .wdog_tick(wdog_tick), .cap_val(cap_val)
);

// File: tb/tb_tmr_capcmp.sv
`timescale 1ns/1ps
module tb_tmr_capcmp;
  localparam int WD = 12;
  localparam int RB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [2:0]  cap_n = 3'b111;
  logic [4:0]  oc_pin, oc_en;
  logic [9:0]  irq;
  logic        wdog_tick;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tmr_capcmp #(.WDOG_LOG2(WD), .RTI_BASE(RB)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_n(cap_n), .oc_pin(oc_pin), .oc_en(oc_en),
    .irq(irq), .wdog_tick(wdog_tick)
  );

  // expected chain and counter, from R1/R2
  logic [WD-1:0] m_chain;
  logic [15:0]   m_cnt;
  logic [1:0]    m_psel = 2'd0;
  logic [15:0]   m_ctrl = 16'd0;
  logic [15:0]   m_act = 16'd0;

  function automatic logic ptick(input logic [WD-1:0] ch, input logic [1:0] ps);
    logic [3:0] mk;
    mk = (ps == 2'd0) ? 4'h0 : (ps == 2'd1) ? 4'h3 : (ps == 2'd2) ? 4'h7 : 4'hF;
    return (ch[3:0] & mk) == mk;
  endfunction

  function automatic logic exp_pin(input logic old, input logic [1:0] a);
    case (a)
      2'd0: return old;
      2'd1: return ~old;
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_chain <= '0;
      m_cnt   <= '0;
    end else begin
      m_chain <= m_chain + 1'b1;
      if (ptick(m_chain, m_psel)) m_cnt <= m_cnt + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 4'd1) m_psel <= d[1:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    do @(negedge clk); while (m_cnt != v);
    #1;
  endtask

  task automatic set_psel(input logic [1:0] ps);
    m_ctrl[1:0] = ps;
    wr(4'd1, m_ctrl);
  endtask

  task automatic cap_event(input int ch, input logic lvl, output logic [15:0] exp);
    @(negedge clk);
    cap_n[ch] = lvl;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp = m_cnt;
    @(negedge clk);
    #1;
  endtask

  task automatic rti_probe(input logic [1:0] rs);
    int w;
    logic [15:0] mask, half;
    w = RB + int'(rs);
    mask = 16'((32'd1 << w) - 1);
    half = 16'(32'd1 << (w - 1));
    m_ctrl[3:2] = rs;
    m_ctrl[1:0] = 2'd3;
    wr(4'd1, m_ctrl);
    do @(negedge clk); while ((m_cnt & mask) != half - 16'd1);
    wr(4'd3, 16'h0002);
    #1 chk("R8 rti cleared", irq[1], 1'b0);
    do @(negedge clk); while ((m_cnt & mask) != half);
    #1 chk("R8 rti not early", irq[1], 1'b0);
    do @(negedge clk); while ((m_cnt & mask) != 16'd0);
    #1 chk("R8 rti period", irq[1], 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d, e, tgt;
    int seed, ch, off, bad, pulses;
    logic [1:0] a, ps;
    logic old;
    seed = $urandom(32'h5eed);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    #1 chk("R12 pins", {oc_pin, oc_en}, 10'h0);
    chk("R12 irq", irq, 10'h0);
    rd(4'd3, d); chk("R12 flags", d, 16'h0);
    rd(4'd8, d); chk("R12 cmp0", d, 16'hFFFF);
    rd(4'd12, d); chk("R12 cmp4", d, 16'hFFFF);
    rd(4'd5, d); chk("R12 cap0", d, 16'h0);
    rd(4'd1, d); chk("R12 ctrl", d, 16'h0);
    rd(4'd0, d); chk("R1 count after reset", d, m_cnt);

    // R1 write ignored
    wr(4'd0, 16'h1234);
    rd(4'd0, d); chk("R1 write ignored", d, m_cnt);

    // R2 each prescale
    for (int p = 0; p < 4; p++) begin
      set_psel(2'(p));
      bad = 0;
      for (int k = 0; k < 80; k++) begin
        rd(4'd0, d);
        if (d != m_cnt) bad++;
      end
      chk("R2 prescale tracking", bad, 0);
    end

    wr(4'd4, 16'h03FF);

    // R6 R7 directed toggle on channel 0
    set_psel(2'd0);
    m_act[1:0] = 2'd1;
    wr(4'd2, m_act);
    #1 chk("R7 enable on", oc_en[0], 1'b1);
    tgt = m_cnt + 16'd20;
    wr(4'd8, tgt);
    wr(4'd3, 16'h0020);
    wait_cnt(tgt);
    chk("R6 flag before match", irq[5], 1'b0);
    chk("R7 pin before match", oc_pin[0], 1'b0);
    wait_cnt(tgt + 16'd1);
    chk("R6 flag at match", irq[5], 1'b1);
    chk("R7 pin toggled", oc_pin[0], 1'b1);

    // R6 R7 random compares
    for (int it = 0; it < 12; it++) begin
      ch = $urandom % 5;
      a = 2'($urandom % 4);
      ps = 2'($urandom % 4);
      off = 14 + int'($urandom % 20);
      set_psel(ps);
      m_act[2*ch +: 2] = a;
      wr(4'd2, m_act);
      #1 chk("R7 enable", oc_en[ch], a != 2'd0);
      tgt = m_cnt + 16'(off);
      wr(4'(8 + ch), tgt);
      wr(4'd3, 16'(1 << (5 + ch)));
      old = oc_pin[ch];
      wait_cnt(tgt);
      chk("R6 random flag before", irq[5+ch], 1'b0);
      wait_cnt(tgt + 16'd1);
      chk("R6 random flag after", irq[5+ch], 1'b1);
      chk("R7 random pin action", oc_pin[ch], exp_pin(old, a));
    end

    // R10 clear on the match edge: set wins
    set_psel(2'd3);
    tgt = m_cnt + 16'd4;
    wr(4'd9, tgt);
    wr(4'd3, 16'h0040);
    do @(negedge clk); while (!(m_cnt == tgt && m_chain[3:0] == 4'hF));
    reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 16'h0040;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    #1 chk("R10 set beats clear", irq[6], 1'b1);
    wr(4'd3, 16'h0040);
    #1 chk("R10 clear", irq[6], 1'b0);

    // R4 R5 captures
    m_ctrl[9:4] = {2'd0, 2'd2, 2'd1};
    wr(4'd1, m_ctrl);
    wr(4'd3, 16'h001C);
    cap_event(0, 1'b0, e);
    chk("R4 ch0 assert flag", irq[2], 1'b1);
    rd(4'd5, d); chk("R4 ch0 value", d, e);
    cap_event(1, 1'b0, e);
    chk("R4 ch1 wrong edge flag", irq[3], 1'b0);
    rd(4'd6, d); chk("R4 ch1 wrong edge value", d, 16'h0);
    cap_event(1, 1'b1, e);
    chk("R4 ch1 release flag", irq[3], 1'b1);
    rd(4'd6, d); chk("R4 ch1 release value", d, e);
    cap_event(2, 1'b0, e);
    cap_event(2, 1'b1, e);
    chk("R5 disabled flag", irq[4], 1'b0);
    rd(4'd7, d); chk("R5 disabled value", d, 16'h0);
    m_ctrl[5:4] = 2'd3;
    wr(4'd1, m_ctrl);
    for (int it = 0; it < 6; it++) begin
      set_psel(2'($urandom % 4));
      repeat ($urandom % 9) @(negedge clk);
      wr(4'd3, 16'h0004);
      cap_event(0, ~cap_n[0], e);
      chk("R4 both-edge flag", irq[2], 1'b1);
      rd(4'd5, d); chk("R4 both-edge value", d, e);
    end

    // R8 periodic rates
    for (int r = 0; r < 4; r++) rti_probe(2'(r));

    // R9 watchdog pulse
    bad = 0; pulses = 0;
    for (int k = 0; k < 2 * (1 << WD) + 20; k++) begin
      @(negedge clk);
      #1;
      if (wdog_tick !== (&m_chain)) bad++;
      if (wdog_tick) pulses++;
    end
    chk("R9 watchdog pattern", bad, 0);
    chk("R9 watchdog count", pulses >= 2, 1'b1);

    // R3 overflow, then R11 masking
    set_psel(2'd0);
    wr(4'd3, 16'h0001);
    wait_cnt(16'hFFFF);
    chk("R3 before wrap", irq[0], 1'b0);
    wait_cnt(16'h0000);
    chk("R3 at wrap", irq[0], 1'b1);
    wr(4'd4, 16'h0001);
    #1 chk("R11 masked irq", irq, 10'h001);
    rd(4'd3, d); chk("R11 raw flag", d[0], 1'b1);
    wr(4'd4, 16'h0000);
    #1 chk("R11 all masked", irq, 10'h000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule